// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Decimal Correction

This block computes one integer operation per clock on 8-bit or 16-bit operands and presents the result, an updated high byte for the ASCII corrections, and six status flags, each paired with its own write-enable bit. The calling pipeline decides which flag bits to commit from the enable vector, so every operation carries its own flag-update rule: some flags are written, some are forced to zero, and others keep the caller's old value because their enable is low.

The operation set covers addition and subtraction with and without an incoming carry or borrow, comparison, increment, decrement, two's-complement negation, the bitwise operations (AND, OR, XOR, a non-writing AND test, complement), and the four decimal corrections. Two of these correct a packed two-digit byte after an addition or subtraction. The other two correct an unpacked digit and carry into or borrow from the high byte. All outputs are registered, so the answer for inputs that are stable before a rising edge appears just after that edge.

Top module: `byte_word_alu`

## Requirements
- R1: While `rst_n` is low, every output is zero. Out of reset, the outputs for inputs present at a rising edge appear after that edge, with one cycle of latency.
- R2: ADD (op 0) and ADC (op 1; adds `cf_i`) produce the sum masked to the selected width (`wide_i`=1 gives 16 bits, 0 gives 8 bits, upper byte 0). They write all six flags: CF is the carry out of the top bit, AF is the carry out of bit 3, and OF is signed overflow.
- R3: SUB (op 2) and SBB (op 3; also subtracts `cf_i`) produce dst minus src. CF is set when the subtrahend, including any borrow, is larger than dst as unsigned values. AF is the borrow from bit 4, and OF is signed overflow. All flags are written.
- R4: CMP (op 4) sets and writes the flags exactly as SUB would, and holds `res_we_o` low.
- R5: INC (op 5) and DEC (op 6) add or subtract one and write AF, PF, ZF, SF and OF, but never CF. Incrementing byte FFh gives 00h with ZF set.
- R6: NEG (op 7) gives zero minus dst. CF is set when dst is nonzero, and OF is set when dst is the most negative value of the width (80h or 8000h). All flags are written.
- R7: AND (op 8), OR (op 9), XOR (op 10) and TEST (op 11; an AND whose `res_we_o` is low) drive CF and OF to 0 with their enables high, write PF, ZF and SF, and do not write AF.
- R8: NOT (op 12) outputs the one's complement of dst at the selected width, with every flag enable low.
- R9: Flag vector bits are CF=0, PF=1, AF=2, ZF=3, SF=4, OF=5. PF is 1 when the low byte of the result holds an even number of ones. ZF and SF follow the result at the selected width. A flag whose enable is low reads 0.
- R10: DAA (op 13) uses only the low byte of dst, and the result upper byte is 0. If the low nibble exceeds 9 or `af_i` is set, the step adds 06h and sets AF. If the original byte exceeds 99h or `cf_i` is set, the step adds 60h and sets CF. It writes CF, AF, PF, ZF and SF. For example, 8Eh becomes 94h.
- R11: DAS (op 14) mirrors R10 using subtraction of 06h and 60h. For example, 2Fh with CF clear becomes 29h.
- R12: AAA (op 15) and AAS (op 16) apply the correction when the low nibble of dst exceeds 9 or `af_i` is set. The correction adds (or subtracts) 06h, increments (or decrements) AH, and sets CF and AF. AL keeps only its low nibble. Only CF and AF are written, and `ah_we_o` is high. For example, 6Eh with AH=00h gives 04h, AH=01h and CF=1. Outside these two ops, `ah_o` repeats `ah_i`.
- R13: Op codes 17 to 31 hold every write-enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 5 | Operation code |
| wide_i | input | 1 | 1 = 16-bit, 0 = 8-bit operation |
| dst_i | input | 16 | Destination (first) operand |
| src_i | input | 16 | Source (second) operand |
| cf_i | input | 1 | Incoming carry flag |
| af_i | input | 1 | Incoming auxiliary-carry flag |
| ah_i | input | 8 | High byte for the ASCII corrections |
| res_o | output | 16 | Result |
| res_we_o | output | 1 | Result should be written back |
| ah_o | output | 8 | Updated high byte |
| ah_we_o | output | 1 | High byte should be written back |
| flags_o | output | 6 | Flag values (CF, PF, AF, ZF, SF, OF at bits 0..5) |
| flags_we_o | output | 6 | Per-flag write enables |

## Verification
The only state is the output register, so any fault surfaces on the edge right after the triggering inputs, never later. A wrong operand mux, carry-in or width mask shows up as a wrong result or a wrong carry at that single edge. A wrong enable mask shows up at the ports as a flag that is written when it should be kept, or kept when it should be written. The decimal corrections are checked near their thresholds (nibble 9 versus Ah, byte 99h versus 9Ah), together with the incoming AF and CF, because an off-by-one compare there flips both the result and CF.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBB  = 5'd3,
        OP_CMP  = 5'd4,
        OP_INC  = 5'd5,
        OP_DEC  = 5'd6,
        OP_NEG  = 5'd7,
        OP_AND  = 5'd8,
        OP_OR   = 5'd9,
        OP_XOR  = 5'd10,
        OP_TEST = 5'd11,
        OP_NOT  = 5'd12,
        OP_DAA  = 5'd13,
        OP_DAS  = 5'd14,
        OP_AAA  = 5'd15,
        OP_AAS  = 5'd16
    } alu_op_e;

    // flag vector positions
    localparam int F_CF  = 0;
    localparam int F_PF  = 1;
    localparam int F_AF  = 2;
    localparam int F_ZF  = 3;
    localparam int F_SF  = 4;
    localparam int F_OF  = 5;
    localparam int NFLAG = 6;

    // bitwise unit selectors
    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOT = 2'd3
    } logic_sel_e;

    // decimal correction kinds
    typedef enum logic [1:0] {
        BC_DAA = 2'd0,
        BC_DAS = 2'd1,
        BC_AAA = 2'd2,
        BC_AAS = 2'd3
    } bcd_kind_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    input  logic              sub_i,
    input  logic              wide_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              carry_o,
    output logic              aux_o,
    output logic              ovf_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

    logic [DATA_W-1:0] mask, am, bm;
    logic [DATA_W:0]   full;
    logic              sa, sb, sr;

    always_comb begin
        mask = wide_i ? {DATA_W{1'b1}} : LOW_MASK;
        am   = a_i & mask;
        bm   = b_i & mask;
        if (sub_i) begin
            full = {1'b0, am} - {1'b0, bm} - {{DATA_W{1'b0}}, cin_i};
        end else begin
            full = {1'b0, am} + {1'b0, bm} + {{DATA_W{1'b0}}, cin_i};
        end
        sum_o   = full[DATA_W-1:0] & mask;
        carry_o = wide_i ? full[DATA_W] : full[HALF_W];
        aux_o   = am[4] ^ bm[4] ^ full[4];
        sa      = wide_i ? am[DATA_W-1]    : am[HALF_W-1];
        sb      = wide_i ? bm[DATA_W-1]    : bm[HALF_W-1];
        sr      = wide_i ? sum_o[DATA_W-1] : sum_o[HALF_W-1];
        if (sub_i) begin
            ovf_o = (sa ^ sb) & (sr ^ sa);
        end else begin
            ovf_o = ~(sa ^ sb) & (sr ^ sa);
        end
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic_sel_e        sel_i,
    output logic [DATA_W-1:0] y_o
);
    logic [DATA_W-1:0] raw;

    always_comb begin
        case (sel_i)
            LG_AND:  raw = a_i & b_i;
            LG_OR:   raw = a_i | b_i;
            LG_XOR:  raw = a_i ^ b_i;
            default: raw = ~a_i;
        endcase
        y_o = raw & mask_i;
    end

endmodule

// File: rtl/alu_bcd.sv
module alu_bcd
    import alu_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] al_i,
    input  logic [BYTE_W-1:0] ah_i,
    input  logic              cf_i,
    input  logic              af_i,
    input  bcd_kind_e         kind_i,
    output logic [BYTE_W-1:0] al_o,
    output logic [BYTE_W-1:0] ah_o,
    output logic              cf_o,
    output logic              af_o
);
    localparam logic [BYTE_W-1:0] LOW_FIX  = BYTE_W'(8'h06);
    localparam logic [BYTE_W-1:0] HIGH_FIX = BYTE_W'(8'h60);
    localparam logic [BYTE_W-1:0] HIGH_LIM = BYTE_W'(8'h99);
    localparam logic [BYTE_W-1:0] NIB_MASK = BYTE_W'(8'h0F);
    localparam logic [BYTE_W-1:0] ONE      = BYTE_W'(1);

    logic              lo_big, hi_big, fix_lo, fix_hi;
    logic [BYTE_W-1:0] step;

    always_comb begin
        lo_big = (al_i[3:0] > 4'd9);
        hi_big = (al_i > HIGH_LIM);
        fix_lo = lo_big | af_i;
        fix_hi = hi_big | cf_i;
        step   = al_i;
        al_o   = al_i;
        ah_o   = ah_i;
        cf_o   = 1'b0;
        af_o   = 1'b0;
        case (kind_i)
            BC_DAA: begin
                step = fix_lo ? al_i + LOW_FIX : al_i;
                al_o = fix_hi ? step + HIGH_FIX : step;
                af_o = fix_lo;
                cf_o = fix_hi;
            end
            BC_DAS: begin
                step = fix_lo ? al_i - LOW_FIX : al_i;
                al_o = fix_hi ? step - HIGH_FIX : step;
                af_o = fix_lo;
                cf_o = fix_hi;
            end
            BC_AAA: begin
                step = fix_lo ? al_i + LOW_FIX : al_i;
                al_o = step & NIB_MASK;
                ah_o = fix_lo ? ah_i + ONE : ah_i;
                af_o = fix_lo;
                cf_o = fix_lo;
            end
            default: begin
                step = fix_lo ? al_i - LOW_FIX : al_i;
                al_o = step & NIB_MASK;
                ah_o = fix_lo ? ah_i - ONE : ah_i;
                af_o = fix_lo;
                cf_o = fix_lo;
            end
        endcase
    end

endmodule

// File: rtl/alu_flagcalc.sv
module alu_flagcalc #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] y_i,
    input  logic              wide_i,
    output logic              pf_o,
    output logic              zf_o,
    output logic              sf_o
);
    localparam int HALF_W = DATA_W / 2;

    logic [HALF_W:0] par_chain;

    // parity chain over the low byte
    assign par_chain[0] = 1'b1;
    for (genvar g = 0; g < HALF_W; g++) begin : g_par
        assign par_chain[g+1] = par_chain[g] ^ y_i[g];
    end

    always_comb begin
        pf_o = par_chain[HALF_W];
        zf_o = wide_i ? (y_i == '0) : (y_i[HALF_W-1:0] == '0);
        sf_o = wide_i ? y_i[DATA_W-1] : y_i[HALF_W-1];
    end

endmodule

// File: rtl/byte_word_alu.sv
module byte_word_alu
    import alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [4:0]          op_i,
    input  logic                wide_i,
    input  logic [DATA_W-1:0]   dst_i,
    input  logic [DATA_W-1:0]   src_i,
    input  logic                cf_i,
    input  logic                af_i,
    input  logic [DATA_W/2-1:0] ah_i,
    output logic [DATA_W-1:0]   res_o,
    output logic                res_we_o,
    output logic [DATA_W/2-1:0] ah_o,
    output logic                ah_we_o,
    output logic [NFLAG-1:0]    flags_o,
    output logic [NFLAG-1:0]    flags_we_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              res_we;
        logic [HALF_W-1:0] ah;
        logic              ah_we;
        logic [NFLAG-1:0]  fl;
        logic [NFLAG-1:0]  we;
    } out_t;

    alu_op_e op;
    assign op = alu_op_e'(op_i);

    // ---------------- operand steering ----------------
    logic [DATA_W-1:0] wmask;
    logic [DATA_W-1:0] as_a, as_b;
    logic              as_cin, as_sub;
    logic_sel_e        lg_sel;
    bcd_kind_e         bc_kind;
    logic              is_arith, is_logic, is_bcd;

    always_comb begin
        wmask   = wide_i ? {DATA_W{1'b1}} : LOW_MASK;
        as_a    = dst_i;
        as_b    = src_i;
        as_cin  = 1'b0;
        as_sub  = 1'b0;
        lg_sel  = LG_AND;
        bc_kind = BC_DAA;
        case (op)
            OP_ADC: as_cin = cf_i;
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_SBB: begin
                as_sub = 1'b1;
                as_cin = cf_i;
            end
            OP_INC: as_b = DATA_W'(1);
            OP_DEC: begin
                as_b   = DATA_W'(1);
                as_sub = 1'b1;
            end
            OP_NEG: begin
                as_a   = '0;
                as_b   = dst_i;
                as_sub = 1'b1;
            end
            OP_OR:  lg_sel = LG_OR;
            OP_XOR: lg_sel = LG_XOR;
            OP_NOT: lg_sel = LG_NOT;
            OP_DAS: bc_kind = BC_DAS;
            OP_AAA: bc_kind = BC_AAA;
            OP_AAS: bc_kind = BC_AAS;
            default: ;
        endcase
        is_arith = (op_i <= 5'd7);
        is_logic = (op_i >= 5'd8)  && (op_i <= 5'd12);
        is_bcd   = (op_i >= 5'd13) && (op_i <= 5'd16);
    end

    // ---------------- datapath units ----------------
    logic [DATA_W-1:0] sum;
    logic              carry, aux, ovf;

    alu_addsub #(.DATA_W(DATA_W)) i_addsub (
        .a_i    (as_a),
        .b_i    (as_b),
        .cin_i  (as_cin),
        .sub_i  (as_sub),
        .wide_i (wide_i),
        .sum_o  (sum),
        .carry_o(carry),
        .aux_o  (aux),
        .ovf_o  (ovf)
    );

    logic [DATA_W-1:0] lg_y;

    alu_logic #(.DATA_W(DATA_W)) i_logic (
        .a_i   (dst_i),
        .b_i   (src_i),
        .mask_i(wmask),
        .sel_i (lg_sel),
        .y_o   (lg_y)
    );

    logic [HALF_W-1:0] bc_al, bc_ah;
    logic              bc_cf, bc_af;

    alu_bcd #(.BYTE_W(HALF_W)) i_bcd (
        .al_i  (dst_i[HALF_W-1:0]),
        .ah_i  (ah_i),
        .cf_i  (cf_i),
        .af_i  (af_i),
        .kind_i(bc_kind),
        .al_o  (bc_al),
        .ah_o  (bc_ah),
        .cf_o  (bc_cf),
        .af_o  (bc_af)
    );

    // ---------------- result pick and status ----------------
    logic [DATA_W-1:0] pick;
    logic              pick_wide;

    always_comb begin
        pick      = '0;
        pick_wide = wide_i;
        if (is_arith) begin
            pick = sum;
        end else if (is_logic) begin
            pick = lg_y;
        end else if (is_bcd) begin
            pick      = {{(DATA_W-HALF_W){1'b0}}, bc_al};
            pick_wide = 1'b0;
        end
    end

    logic pf, zf, sf;

    alu_flagcalc #(.DATA_W(DATA_W)) i_flags (
        .y_i   (pick),
        .wide_i(pick_wide),
        .pf_o  (pf),
        .zf_o  (zf),
        .sf_o  (sf)
    );

    // ---------------- next-state assembly ----------------
    out_t out_d, out_q;

    always_comb begin
        out_d        = '0;
        out_d.ah     = ah_i;
        out_d.res    = pick;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP, OP_NEG: begin
                out_d.res_we    = (op != OP_CMP);
                out_d.fl[F_CF]  = carry;
                out_d.fl[F_PF]  = pf;
                out_d.fl[F_AF]  = aux;
                out_d.fl[F_ZF]  = zf;
                out_d.fl[F_SF]  = sf;
                out_d.fl[F_OF]  = ovf;
                out_d.we        = '1;
            end
            OP_INC, OP_DEC: begin
                out_d.res_we    = 1'b1;
                out_d.fl[F_PF]  = pf;
                out_d.fl[F_AF]  = aux;
                out_d.fl[F_ZF]  = zf;
                out_d.fl[F_SF]  = sf;
                out_d.fl[F_OF]  = ovf;
                out_d.we        = '1;
                out_d.we[F_CF]  = 1'b0;
            end
            OP_AND, OP_OR, OP_XOR, OP_TEST: begin
                out_d.res_we    = (op != OP_TEST);
                out_d.fl[F_PF]  = pf;
                out_d.fl[F_ZF]  = zf;
                out_d.fl[F_SF]  = sf;
                out_d.we        = '1;
                out_d.we[F_AF]  = 1'b0;
            end
            OP_NOT: begin
                out_d.res_we    = 1'b1;
            end
            OP_DAA, OP_DAS: begin
                out_d.res_we    = 1'b1;
                out_d.fl[F_CF]  = bc_cf;
                out_d.fl[F_PF]  = pf;
                out_d.fl[F_AF]  = bc_af;
                out_d.fl[F_ZF]  = zf;
                out_d.fl[F_SF]  = sf;
                out_d.we        = '1;
                out_d.we[F_OF]  = 1'b0;
            end
            OP_AAA, OP_AAS: begin
                out_d.res_we    = 1'b1;
                out_d.ah        = bc_ah;
                out_d.ah_we     = 1'b1;
                out_d.fl[F_CF]  = bc_cf;
                out_d.fl[F_AF]  = bc_af;
                out_d.we[F_CF]  = 1'b1;
                out_d.we[F_AF]  = 1'b1;
            end
            default: begin
                out_d.res = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign res_o      = out_q.res;
    assign res_we_o   = out_q.res_we;
    assign ah_o       = out_q.ah;
    assign ah_we_o    = out_q.ah_we;
    assign flags_o    = out_q.fl;
    assign flags_we_o = out_q.we;

endmodule

// File: rtl/alu_checker.sv
module alu_checker
    import alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        op_i,
    input logic              wide_i,
    input logic [DATA_W-1:0] dst_i,
    input logic [DATA_W-1:0] src_i,
    input logic [DATA_W-1:0] res_o,
    input logic              res_we_o,
    input logic              ah_we_o,
    input logic [NFLAG-1:0]  flags_o,
    input logic [NFLAG-1:0]  flags_we_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    // R3: word subtraction borrow equals unsigned compare of the operands
    p_sub_borrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SUB && wide_i) |=> (flags_o[F_CF] == ($past(dst_i) < $past(src_i))));

    // R4: compare never requests a write-back but writes flags
    p_cmp_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CMP) |=> (!res_we_o && flags_we_o[F_CF] && flags_we_o[F_ZF]));

    // R5: increment and decrement keep CF
    p_incdec_keep_cf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_INC || op_i == OP_DEC) |=> !flags_we_o[F_CF]);

    // R6: negating the most negative word overflows
    p_neg_most_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_NEG && wide_i && dst_i == MOST_NEG) |=> (flags_o[F_OF] && flags_we_o[F_OF]));

    // R7: bitwise ops clear CF and OF and leave AF alone
    p_logic_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= OP_AND && op_i <= OP_TEST) |=>
            (!flags_o[F_CF] && !flags_o[F_OF] && flags_we_o[F_CF] && flags_we_o[F_OF] && !flags_we_o[F_AF]));

    // R8: complement writes no flag
    p_not_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_NOT) |=> (flags_we_o == '0 && res_we_o));

    // R9: parity follows the low byte of the presented result
    p_parity_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we_o[F_PF] |-> (flags_o[F_PF] == ~^res_o[HALF_W-1:0]));

    // R9: zero flag follows the presented result
    p_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we_o[F_ZF] |-> (flags_o[F_ZF] == (res_o == '0)));

    // R13: unused codes write nothing
    p_unused_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > OP_AAS) |=> (flags_we_o == '0 && !res_we_o && !ah_we_o));

    // R12: high byte is only written by the ASCII corrections
    p_ah_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_AAA && op_i != OP_AAS) |=> !ah_we_o);

endmodule

bind byte_word_alu alu_checker #(.DATA_W(DATA_W)) i_alu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op_i),
    .wide_i    (wide_i),
    .dst_i     (dst_i),
    .src_i     (src_i),
    .res_o     (res_o),
    .res_we_o  (res_we_o),
    .ah_we_o   (ah_we_o),
    .flags_o   (flags_o),
    .flags_we_o(flags_we_o)
);

// File: tb/test_byte_word_alu.sv
`timescale 1ns/1ps
module test_byte_word_alu;

    typedef struct packed {
        logic [15:0] res;
        logic        res_we;
        logic [7:0]  ah;
        logic        ah_we;
        logic [5:0]  fl;
        logic [5:0]  we;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_i = '0;
    logic        wide_i = 1'b0;
    logic [15:0] dst_i = '0;
    logic [15:0] src_i = '0;
    logic        cf_i = 1'b0;
    logic        af_i = 1'b0;
    logic [7:0]  ah_i = '0;
    logic [15:0] res_o;
    logic        res_we_o;
    logic [7:0]  ah_o;
    logic        ah_we_o;
    logic [5:0]  flags_o;
    logic [5:0]  flags_we_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    byte_word_alu i_byte_word_alu (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .wide_i(wide_i),
        .dst_i(dst_i), .src_i(src_i), .cf_i(cf_i), .af_i(af_i), .ah_i(ah_i),
        .res_o(res_o), .res_we_o(res_we_o), .ah_o(ah_o), .ah_we_o(ah_we_o),
        .flags_o(flags_o), .flags_we_o(flags_we_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            bad++;
            total++;
            $display("FAIL R1 watchdog expired: actual=%0d cycles expected=<50000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic string tag_of(int op);
        case (op)
            0, 1:        return "R2";
            2, 3:        return "R3";
            4:           return "R4";
            5, 6:        return "R5";
            7:           return "R6";
            8, 9, 10, 11: return "R7";
            12:          return "R8";
            13:          return "R10";
            14:          return "R11";
            15, 16:      return "R12";
            default:     return "R13";
        endcase
    endfunction

    // parity, zero, sign into an expected flag vector
    function automatic logic [5:0] pzs(int r, bit w);
        logic [5:0] f = '0;
        int ones = 0;
        for (int k = 0; k < 8; k++) ones += (r >> k) & 1;
        f[1] = (ones % 2) == 0;
        f[3] = (r == 0);
        f[4] = w ? ((r >> 15) & 1) : ((r >> 7) & 1);
        return f;
    endfunction

    function automatic exp_t model(int op, bit w, int d, int s, bit c, bit a, int h);
        exp_t e = '0;
        int mask = w ? 32'hFFFF : 32'hFF;
        int msb  = w ? 32'h8000 : 32'h80;
        e.ah = h[7:0];
        if (op <= 7) begin
            int x = d & mask;
            int y = s & mask;
            int ci = 0;
            bit sub = 0;
            int t, r;
            bit cf, af, of, sx, sy, sr;
            case (op)
                1: ci = c;
                2, 4: sub = 1;
                3: begin sub = 1; ci = c; end
                5: y = 1;
                6: begin y = 1; sub = 1; end
                7: begin y = x; x = 0; sub = 1; end
                default: ;
            endcase
            if (!sub) begin
                t  = x + y + ci;
                cf = t > mask;
                af = ((x & 15) + (y & 15) + ci) > 15;
            end else begin
                t  = x - y - ci;
                cf = x < (y + ci);
                af = (x & 15) < ((y & 15) + ci);
            end
            r  = t & mask;
            sx = (x & msb) != 0;
            sy = (y & msb) != 0;
            sr = (r & msb) != 0;
            of = sub ? (sx != sy && sr != sx) : (sx == sy && sr != sx);
            e.res    = r[15:0];
            e.res_we = (op != 4);
            e.fl     = pzs(r, w);
            e.fl[2]  = af;
            e.fl[5]  = of;
            e.we     = 6'h3F;
            if (op == 5 || op == 6) e.we[0] = 1'b0;
            else e.fl[0] = cf;
        end else if (op <= 11) begin
            int r;
            if (op == 9) r = (d | s) & mask;
            else if (op == 10) r = (d ^ s) & mask;
            else r = (d & s) & mask;
            e.res    = r[15:0];
            e.res_we = (op != 11);
            e.fl     = pzs(r, w);
            e.we     = 6'b111011;
        end else if (op == 12) begin
            e.res    = 16'((~d) & mask);
            e.res_we = 1'b1;
        end else if (op <= 14) begin
            int al = d & 255;
            bit s1 = ((al & 15) > 9) || a;
            bit s2 = (al > 'h99) || c;
            int t, r;
            if (op == 13) begin
                t = s1 ? ((al + 6) & 255) : al;
                r = s2 ? ((t + 'h60) & 255) : t;
            end else begin
                t = s1 ? ((al - 6) & 255) : al;
                r = s2 ? ((t - 'h60) & 255) : t;
            end
            e.res    = r[15:0];
            e.res_we = 1'b1;
            e.fl     = pzs(r, 0);
            e.fl[0]  = s2;
            e.fl[2]  = s1;
            e.we     = 6'h1F;
        end else if (op <= 16) begin
            int al = d & 255;
            bit fix = ((al & 15) > 9) || a;
            int r;
            if (op == 15) begin
                r = fix ? ((al + 6) & 15) : (al & 15);
                if (fix) e.ah = 8'((h + 1) & 255);
            end else begin
                r = fix ? ((al - 6) & 15) : (al & 15);
                if (fix) e.ah = 8'((h - 1) & 255);
            end
            e.res    = r[15:0];
            e.res_we = 1'b1;
            e.ah_we  = 1'b1;
            e.fl[0]  = fix;
            e.fl[2]  = fix;
            e.we     = 6'b000101;
        end
        return e;
    endfunction

    task automatic check_val(string tag, string what, int act, int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // drive one operation, wait one edge, compare everything with the model
    task automatic run(int op, bit w, int d, int s, bit c, bit a, int h);
        exp_t e, got;
        @(negedge clk);
        op_i   = op[4:0];
        wide_i = w;
        dst_i  = d[15:0];
        src_i  = s[15:0];
        cf_i   = c;
        af_i   = a;
        ah_i   = h[7:0];
        e = model(op, w, d, s, c, a, h);
        @(posedge clk);
        #1;
        got = {res_o, res_we_o, ah_o, ah_we_o, flags_o, flags_we_o};
        total++;
        if (got !== e) begin
            bad++;
            $display("FAIL %s op=%0d w=%0d d=%h s=%h: actual=%h expected=%h",
                     tag_of(op), op, w, d[15:0], s[15:0], got, e);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check_val("R1", "reset outputs",
                  int'({res_o, res_we_o, ah_o, ah_we_o, flags_o, flags_we_o} != '0), 0);
        rst_n = 1'b1;

        // R2: packed addition example, then R10 correction
        run(0, 0, 'h59, 'h35, 0, 0, 0);
        check_val("R2", "59h+35h", res_o, 'h8E);
        run(13, 0, 'h8E, 0, 0, 0, 0);
        check_val("R10", "DAA of 8Eh", res_o, 'h94);
        check_val("R10", "DAA CF", flags_o[0], 0);
        run(13, 0, 'h9A, 0, 0, 0, 0);
        check_val("R10", "DAA of 9Ah", res_o, 'h00);
        check_val("R10", "DAA 9Ah CF", flags_o[0], 1);
        // R11
        run(14, 0, 'h2F, 0, 0, 0, 0);
        check_val("R11", "DAS of 2Fh", res_o, 'h29);
        // R12
        run(15, 0, 'h6E, 0, 0, 0, 'h00);
        check_val("R12", "AAA AL", res_o, 'h04);
        check_val("R12", "AAA AH", ah_o, 'h01);
        check_val("R12", "AAA CF", flags_o[0], 1);
        run(16, 0, 'hFC, 0, 0, 0, 'h05);
        check_val("R12", "AAS AH", ah_o, 'h04);
        // R5
        run(5, 0, 'hFF, 0, 1, 0, 0);
        check_val("R5", "INC FFh", res_o, 0);
        check_val("R5", "INC ZF", flags_o[3], 1);
        check_val("R5", "INC CF enable", flags_we_o[0], 0);
        // R6
        run(7, 1, 'h8000, 0, 0, 0, 0);
        check_val("R6", "NEG 8000h OF", flags_o[5], 1);
        run(7, 0, 'h80, 0, 0, 0, 0);
        check_val("R6", "NEG 80h OF", flags_o[5], 1);
        run(7, 0, 'h00, 0, 0, 0, 0);
        check_val("R6", "NEG 0 CF", flags_o[0], 0);
        // R3
        run(2, 0, 'h03, 'h05, 0, 0, 0);
        check_val("R3", "SUB borrow", flags_o[0], 1);
        run(3, 1, 'h1000, 'h0FFF, 1, 0, 0);
        check_val("R3", "SBB equal plus borrow", flags_o[0], 0);
        // R4
        run(4, 1, 'h1234, 'h1234, 0, 0, 0);
        check_val("R4", "CMP write", res_we_o, 0);
        check_val("R4", "CMP ZF", flags_o[3], 1);
        // R7
        run(11, 0, 'hF0, 'h0F, 1, 1, 0);
        check_val("R7", "TEST write", res_we_o, 0);
        check_val("R7", "TEST ZF", flags_o[3], 1);
        // R8
        run(12, 1, 'h00FF, 0, 0, 0, 0);
        check_val("R8", "NOT value", res_o, 'hFF00);
        check_val("R8", "NOT enables", flags_we_o, 0);
        // R9
        run(8, 0, 'h03, 'hFF, 0, 0, 0);
        check_val("R9", "parity of 03h", flags_o[1], 1);
        run(8, 0, 'h07, 'hFF, 0, 0, 0);
        check_val("R9", "parity of 07h", flags_o[1], 0);
        run(0, 1, 'h7F00, 'h0100, 0, 0, 0);
        check_val("R9", "word SF", flags_o[4], 1);
        // R2 word carry out
        run(0, 1, 'hFFFF, 'h0001, 0, 0, 0);
        check_val("R2", "word wrap CF", flags_o[0], 1);
        check_val("R2", "word wrap ZF", flags_o[3], 1);
        // R13
        run(25, 1, 'h1234, 'h4321, 1, 1, 'h55);
        check_val("R13", "unused code enables", flags_we_o, 0);

        // random mix over all codes and widths
        for (int i = 0; i < 600; i++) begin
            run(int'($urandom % 20), bit'($urandom % 2), int'($urandom & 'hFFFF),
                int'($urandom & 'hFFFF), bit'($urandom % 2), bit'($urandom % 2),
                int'($urandom & 'hFF));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule